// File: doc/BRIEF.md
# Video Status Flags and Interrupt Controller

This block holds the status flags of a video processor and drives its CPU interrupt request. The video timing logic supplies single-cycle pulses for the frame end and for the line-counter event, and the sprite logic supplies pulses for sprite overflow and sprite collision. Each pulse sets a sticky flag. A CPU status read returns the flags with the unused low bits forced to 1. The same read clears every flag, both interrupt sources and the control-port byte-sequence state.

Two control-register bits decide which sources may interrupt. Bit 5 of register 1 enables the frame source, and bit 4 of register 0 enables the line source. The interrupt line is the OR of each pending source gated by its enable. It is re-evaluated on every clock edge, so a write that sets or clears an enable takes effect at once, including while a source is already pending. A read that coincides with a new event clears the old flags first and then latches the new event, so no event is lost.

Top module: `vdp_stat_irq`

## Requirements
- R1: After reset, `irq` is 0, `seq_clr` is 0, `stat_q` is 0x1F, all flags are clear and both enables are 0.
- R2: A `frame_evt` pulse sets status bit 7. The bit stays set until a status read.
- R3: A `spr_ovf_evt` pulse sets status bit 6 and a `spr_col_evt` pulse sets status bit 5. Neither one affects `irq`.
- R4: A `stat_rd` strobe loads `stat_q` on the same edge with {bit7, bit6, bit5, 5'b11111}, taken from the flags held before that edge. `stat_q` holds that value until the next read.
- R5: A status read clears bits 7, 6 and 5 and the pending line source, so an immediately following read returns 0x1F.
- R6: An event that arrives in the same cycle as a read is not reported by that read, but its flag is set after it.
- R7: `irq` is registered and equals (frame pending AND frame enable) OR (line pending AND line enable), one cycle after the cause.
- R8: A write of register index 1 sets the frame enable from data bit 5. With a frame event pending, `irq` follows the new bit one cycle after the write.
- R9: A write of register index 0 sets the line enable from data bit 4. With a line event pending, `irq` follows the new bit one cycle after the write.
- R10: A status read with no coinciding frame or line event drops `irq` one cycle later. It also pulses `seq_clr` high for exactly that one cycle.
- R11: Register writes to any index other than 0 and 1 leave both enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_evt | input | 1 | Frame-end event pulse |
| line_evt | input | 1 | Line-counter event pulse |
| spr_ovf_evt | input | 1 | Sprite overflow event pulse |
| spr_col_evt | input | 1 | Sprite collision event pulse |
| reg_wr | input | 1 | Control register write strobe |
| reg_idx | input | 4 | Control register index |
| reg_data | input | 8 | Control register write data |
| stat_rd | input | 1 | Status read strobe |
| stat_q | output | 8 | Status byte captured by the last read |
| irq | output | 1 | Interrupt request, active high |
| seq_clr | output | 1 | One-cycle pulse that resets the control-port byte sequence |

## Verification
Every output of this block is a register, so each result is due exactly one edge after its stimulus. This holds for an event pulse and `irq`, for an enable write and `irq`, and for a read strobe and both `stat_q` and `seq_clr`. The bench drives a strobe for one cycle, waits for one rising edge plus a small delay, and samples there, so it always observes the first cycle in which the result is valid. The sweep covers all sixteen event combinations under all four enable settings. It also covers enable toggling while a source is pending and events that land in the same cycle as a read, and it computes every expected byte and interrupt level in the bench from the requirement formulas.

// File: rtl/vdp_stat_pkg.sv
package vdp_stat_pkg;
  parameter int STAT_W   = 8;
  parameter int IDX_W    = 4;
  parameter int FRM_BIT  = 7;
  parameter int OVF_BIT  = 6;
  parameter int COL_BIT  = 5;
  parameter int FEN_BIT  = 5;
  parameter int LEN_BIT  = 4;
  parameter int FEN_REG  = 1;
  parameter int LEN_REG  = 0;
  localparam int LOW_W   = COL_BIT;
  localparam logic [STAT_W-1:0] LOW_ONES = STAT_W'((1 << LOW_W) - 1);
endpackage

// File: rtl/vdp_flag_bank.sv
module vdp_flag_bank (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic frame_evt,
  input  logic line_evt,
  input  logic ovf_evt,
  input  logic col_evt,
  output logic frm_q,
  output logic ovf_q,
  output logic col_q,
  output logic frm_d,
  output logic line_d
);
  logic line_q, ovf_d, col_d;

  always_comb begin
    frm_d  = (frm_q  & ~clr) | frame_evt;
    line_d = (line_q & ~clr) | line_evt;
    ovf_d  = (ovf_q  & ~clr) | ovf_evt;
    col_d  = (col_q  & ~clr) | col_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_q <= 1'b0; line_q <= 1'b0; ovf_q <= 1'b0; col_q <= 1'b0;
    end else begin
      frm_q <= frm_d; line_q <= line_d; ovf_q <= ovf_d; col_q <= col_d;
    end
  end

  // R5
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    clr && !frame_evt && !ovf_evt && !col_evt |=> !frm_q && !ovf_q && !col_q);
  // R6
  event_survives_read_chk: assert property (@(posedge clk) disable iff (rst)
    frame_evt |=> frm_q);
endmodule

// File: rtl/vdp_enable_regs.sv
module vdp_enable_regs
  import vdp_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [STAT_W-1:0] data,
  output logic              fen_d,
  output logic              len_d
);
  logic fen_q, len_q;

  always_comb begin
    fen_d = (wr && idx == IDX_W'(FEN_REG)) ? data[FEN_BIT] : fen_q;
    len_d = (wr && idx == IDX_W'(LEN_REG)) ? data[LEN_BIT] : len_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fen_q <= 1'b0; len_q <= 1'b0;
    end else begin
      fen_q <= fen_d; len_q <= len_d;
    end
  end

  // R11
  other_index_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr && idx != IDX_W'(FEN_REG) && idx != IDX_W'(LEN_REG) |=> $stable(fen_q) && $stable(len_q));
endmodule

// File: rtl/vdp_irq_gen.sv
module vdp_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic frm_pend,
  input  logic line_pend,
  input  logic fen,
  input  logic len,
  output logic irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= (frm_pend & fen) | (line_pend & len);
  end
endmodule

// File: rtl/vdp_stat_irq.sv
module vdp_stat_irq
  import vdp_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_evt,
  input  logic              line_evt,
  input  logic              spr_ovf_evt,
  input  logic              spr_col_evt,
  input  logic              reg_wr,
  input  logic [IDX_W-1:0]  reg_idx,
  input  logic [STAT_W-1:0] reg_data,
  input  logic              stat_rd,
  output logic [STAT_W-1:0] stat_q,
  output logic              irq,
  output logic              seq_clr
);
  logic frm_q, ovf_q, col_q, frm_d, line_d, fen_d, len_d;
  logic [STAT_W-1:0] rd_val;

  vdp_flag_bank u_flags (
    .clk(clk), .rst(rst), .clr(stat_rd),
    .frame_evt(frame_evt), .line_evt(line_evt),
    .ovf_evt(spr_ovf_evt), .col_evt(spr_col_evt),
    .frm_q(frm_q), .ovf_q(ovf_q), .col_q(col_q),
    .frm_d(frm_d), .line_d(line_d)
  );

  vdp_enable_regs u_en (
    .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx), .data(reg_data),
    .fen_d(fen_d), .len_d(len_d)
  );

  vdp_irq_gen u_irq (
    .clk(clk), .rst(rst), .frm_pend(frm_d), .line_pend(line_d),
    .fen(fen_d), .len(len_d), .irq(irq)
  );

  always_comb begin
    rd_val = LOW_ONES;
    rd_val[FRM_BIT] = frm_q;
    rd_val[OVF_BIT] = ovf_q;
    rd_val[COL_BIT] = col_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= LOW_ONES;
      seq_clr <= 1'b0;
    end else begin
      seq_clr <= stat_rd;
      if (stat_rd) stat_q <= rd_val;
    end
  end

  // R4
  low_bits_ones_chk: assert property (@(posedge clk) disable iff (rst)
    stat_q[LOW_W-1:0] == LOW_ONES[LOW_W-1:0]);
  // R10
  read_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    stat_rd && !frame_evt && !line_evt |=> !irq && seq_clr);
  // R10
  seq_clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    !stat_rd |=> !seq_clr);
  // R3
  sprite_no_irq_chk: assert property (@(posedge clk) disable iff (rst)
    !irq && !frame_evt && !line_evt && !reg_wr |=> !irq);
endmodule

// File: tb/tb_vdp_stat_irq.sv
module tb_vdp_stat_irq;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_evt = 0, line_evt = 0, spr_ovf_evt = 0, spr_col_evt = 0;
  logic reg_wr = 0, stat_rd = 0;
  logic [3:0] reg_idx = 0;
  logic [7:0] reg_data = 0;
  logic [7:0] stat_q;
  logic irq, seq_clr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vdp_stat_irq dut (.*);

  task automatic chk(string req, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
    frame_evt = 0; line_evt = 0; spr_ovf_evt = 0; spr_col_evt = 0;
    reg_wr = 0; stat_rd = 0;
  endtask

  task automatic wr_reg(logic [3:0] i, logic [7:0] d);
    reg_wr = 1; reg_idx = i; reg_data = d; step();
  endtask

  task automatic rd_stat();
    stat_rd = 1; step();
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    step(); step();
    rst = 0;
    // R1 reset state
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 seq_clr", {7'd0, seq_clr}, 8'h00);
    chk("R1 stat_q", stat_q, 8'h1F);

    // Sweep enables x events: R2 R3 R4 R5 R7 R10
    for (int e = 0; e < 4; e++) begin
      wr_reg(4'd1, (e & 1) ? 8'h20 : 8'h00);
      wr_reg(4'd0, (e & 2) ? 8'h10 : 8'h00);
      for (int v = 0; v < 16; v++) begin
        logic f, l, o, c, exp_irq;
        f = v[0]; l = v[1]; o = v[2]; c = v[3];
        frame_evt = f; line_evt = l; spr_ovf_evt = o; spr_col_evt = c;
        step();
        exp_irq = (f & e[0]) | (l & e[1]);
        chk("R7 irq after event", {7'd0, irq}, {7'd0, exp_irq});
        chk("R3 sprite flags do not raise irq", {7'd0, irq & ~(f | l)}, 8'h00);
        rd_stat();
        chk("R4 R2 R3 status byte", stat_q, {f, o, c, 5'h1F});
        chk("R10 irq after read", {7'd0, irq}, 8'h00);
        chk("R10 seq_clr pulse", {7'd0, seq_clr}, 8'h01);
        step();
        chk("R10 seq_clr single", {7'd0, seq_clr}, 8'h00);
        chk("R4 stat_q held", stat_q, {f, o, c, 5'h1F});
        rd_stat();
        chk("R5 second read", stat_q, 8'h1F);
      end
    end

    // R5 line pending cleared by read: enable after read keeps irq low
    wr_reg(4'd0, 8'h00);
    line_evt = 1; step();
    rd_stat();
    wr_reg(4'd0, 8'h10);
    chk("R5 line pending cleared", {7'd0, irq}, 8'h00);

    // R8 frame enable toggle with frame pending
    wr_reg(4'd1, 8'h00);
    frame_evt = 1; step();
    chk("R8 disabled no irq", {7'd0, irq}, 8'h00);
    wr_reg(4'd1, 8'h20);
    chk("R8 enable raises irq", {7'd0, irq}, 8'h01);
    wr_reg(4'd1, 8'hDF);
    chk("R8 disable drops irq", {7'd0, irq}, 8'h00);
    rd_stat();

    // R9 line enable toggle with line pending
    wr_reg(4'd0, 8'h00);
    line_evt = 1; step();
    chk("R9 disabled no irq", {7'd0, irq}, 8'h00);
    wr_reg(4'd0, 8'h10);
    chk("R9 enable raises irq", {7'd0, irq}, 8'h01);
    // R11 other indices ignored
    for (int i = 2; i < 16; i++) begin
      wr_reg(i[3:0], 8'h00);
      chk("R11 other index ignored", {7'd0, irq}, 8'h01);
    end
    wr_reg(4'd0, 8'hEF);
    chk("R9 disable drops irq", {7'd0, irq}, 8'h00);
    rd_stat();

    // R6 event in same cycle as read
    wr_reg(4'd1, 8'h20);
    frame_evt = 1; stat_rd = 1; step();
    chk("R6 read misses new event", stat_q, 8'h1F);
    chk("R6 irq from new event", {7'd0, irq}, 8'h01);
    rd_stat();
    chk("R6 flag kept", stat_q, 8'h9F);
    chk("R6 irq dropped", {7'd0, irq}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule